// File: doc/BRIEF.md
# Serial NOR Flash Emulator

This block behaves as a small serial NOR flash on an SPI bus, so that a flash controller can be exercised in simulation or on a prototype without an external memory model. It answers the usual command set: write enable, write disable, status read, data read, page program, sector erase, bulk erase and signature read. A byte-wide array, sized by a parameter, stands in for the flash cells.

The SPI pins are sampled with the system clock, so the serial clock must be several times slower than `clk`. The emulator models the write-enable latch, a write-in-progress flag that stays up for a configurable number of cycles after a program or erase, AND-style programming into erased cells, and the wrap of programming within one 256-byte page. After reset the array is cleared to 0xFF in the background while write-in-progress is held.

Top module: `nor_flash_emu`

## Requirements
- R1: After reset the status reads WIP=1 while the whole array is set to 0xFF; afterwards status is 0x00 and every byte reads 0xFF.
- R2: Opcode 0x05 returns the status byte, with bit 0 = WIP and bit 1 = WEL and all other bits 0, once per byte for as long as chip select stays low, each byte showing the state at its own byte boundary.
- R3: Opcode 0x06 sets WEL and opcode 0x04 clears it, each taking effect when chip select deasserts.
- R4: Opcode 0x03 followed by a 3-byte address (most significant byte first, upper bits beyond the array ignored) returns bytes from consecutive addresses, wrapping from the last address to address 0.
- R5: Opcode 0x02 followed by a 3-byte address and data bytes ANDs each data byte into the stored byte; the column advances modulo 256 so data past the page end continues at offset 0 of the same page.
- R6: Opcode 0xD8 with a 3-byte address sets every byte of the 2^SECTOR_BITS-byte sector holding that address to 0xFF and leaves other sectors intact; opcode 0xC7 alone sets the whole array to 0xFF.
- R7: Program, sector erase and bulk erase issued while WEL=0 change neither the array nor the status.
- R8: A program with at least one data byte, or an accepted erase, sets WIP at chip-select deassertion for at least BUSY_CYCLES clocks (erases also until the array walk ends); WEL and WIP clear in the same cycle at completion.
- R9: While WIP=1 every command other than 0x05 is ignored: write enable leaves WEL unchanged and a data read returns 0x00.
- R10: Opcode 0xAB followed by 3 dummy bytes returns the density code 0x13 + DENSITY_SEL (8, 16, 32, 64 Mbit for 0..3), repeated while chip select stays low.
- R11: SPI mode 0: input bits are sampled on the rising serial clock, output bits change on the falling edge, most significant bit first; `miso` is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |

## Verification
The end of a program can land in the middle of a status read that streams bytes under a single chip select, so the completion of the busy period and the loading of a status byte fall in the same cycle window. The bench starts a program and at once opens one long status read that spans the whole busy time. Every returned byte must be either 0x03 or 0x00, the first 0x03 and the last 0x00, with no 0x03 after a 0x00; a byte of 0x01 or 0x02 would show that the latch and the busy flag drop in different cycles.

// File: rtl/nor_flash_emu.sv
module nor_flash_emu #(
  parameter int ADDR_BITS   = 10,
  parameter int SECTOR_BITS = 9,
  parameter int BUSY_CYCLES = 64,
  parameter int DENSITY_SEL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_BITS-1:0] SEC_MASK = ADDR_BITS'((1 << SECTOR_BITS) - 1);
  localparam logic [ADDR_BITS-1:0] LAST     = ADDR_BITS'(DEPTH - 1);
  localparam logic [7:0] SIG = 8'h13 + 8'(DENSITY_SEL);

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_RES  = 8'hAB;

  logic [7:0] mem [DEPTH];

  logic [2:0] cs_q, sck_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt, byte_cnt;
  logic [6:0] shreg;
  logic [7:0] cmd, tx_sr, tx_next, rx_byte, status;
  logic [ADDR_BITS-1:0] addr, addr_in, ra, er_ptr, er_end;
  logic [CNT_W-1:0] busy_cnt;
  logic data_seen, wel, er_act;
  logic cs_low, cs_rise, sck_rise, sck_fall, byte_done;
  logic wip, wip_nxt, fin, op_ok, start_op, prog_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= 3'b111;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
    end else begin
      cs_q   <= {cs_q[1:0], cs_n};
      sck_q  <= {sck_q[1:0], sclk};
      mosi_q <= {mosi_q[0], mosi};
    end

  assign cs_low    = !cs_q[1];
  assign cs_rise   = cs_q[1] && !cs_q[2];
  assign sck_rise  = sck_q[1] && !sck_q[2];
  assign sck_fall  = !sck_q[1] && sck_q[2];
  assign byte_done = cs_low && sck_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {shreg, mosi_q[1]};
  assign addr_in   = ADDR_BITS'({addr, rx_byte});
  assign ra        = (byte_cnt == 3'd3) ? addr_in : addr;

  assign wip     = (busy_cnt != '0) || er_act;
  assign wip_nxt = (busy_cnt > CNT_W'(1)) || (er_act && (er_ptr != er_end));
  assign fin     = wip && !wip_nxt;
  assign status  = {6'b0, wel, wip};
  assign miso    = cs_low ? tx_sr[7] : 1'b0;

  assign prog_we  = byte_done && (cmd == OP_PP) && (byte_cnt == 3'd4);
  assign start_op = cs_rise && (((cmd == OP_PP) && data_seen) ||
                                ((cmd == OP_SE) && (byte_cnt == 3'd4)) ||
                                (cmd == OP_BE));

  always_comb begin
    op_ok = 1'b0;
    case (rx_byte)
      OP_RDSR:                op_ok = 1'b1;
      OP_WREN, OP_WRDI,
      OP_READ, OP_RES:        op_ok = !wip;
      OP_PP, OP_SE, OP_BE:    op_ok = !wip && wel;
      default:                op_ok = 1'b0;
    endcase
    tx_next = 8'h00;
    if (byte_cnt == 3'd0) begin
      if (op_ok && rx_byte == OP_RDSR) tx_next = status;
    end else begin
      case (cmd)
        OP_RDSR: tx_next = status;
        OP_READ: if (byte_cnt >= 3'd3) tx_next = mem[ra];
        OP_RES:  if (byte_cnt >= 3'd3) tx_next = SIG;
        default: tx_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      shreg     <= '0;
      cmd       <= '0;
      addr      <= '0;
      tx_sr     <= '0;
      data_seen <= 1'b0;
    end else if (!cs_low) begin
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      cmd       <= '0;
      tx_sr     <= '0;
      data_seen <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (sck_fall && bit_cnt != 3'd0)
        tx_sr <= {tx_sr[6:0], 1'b0};
      if (byte_done) begin
        tx_sr <= tx_next;
        if (byte_cnt != 3'd4) byte_cnt <= byte_cnt + 3'd1;
        if (byte_cnt == 3'd0)
          cmd <= op_ok ? rx_byte : 8'h00;
        else if (cmd == OP_READ && byte_cnt >= 3'd3)
          addr <= ra + ADDR_BITS'(1);
        else if (byte_cnt <= 3'd3)
          addr <= addr_in;
        else if (cmd == OP_PP) begin
          addr      <= {addr[ADDR_BITS-1:8], addr[7:0] + 8'd1};
          data_seen <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel      <= 1'b0;
      busy_cnt <= '0;
      er_act   <= 1'b1;
      er_ptr   <= '0;
      er_end   <= LAST;
    end else begin
      if (fin) wel <= 1'b0;
      else if (cs_rise && cmd == OP_WREN) wel <= 1'b1;
      else if (cs_rise && cmd == OP_WRDI) wel <= 1'b0;

      if (start_op) busy_cnt <= CNT_W'(BUSY_CYCLES);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - CNT_W'(1);

      if (start_op && cmd == OP_SE) begin
        er_act <= 1'b1;
        er_ptr <= addr & ~SEC_MASK;
        er_end <= addr | SEC_MASK;
      end else if (start_op && cmd == OP_BE) begin
        er_act <= 1'b1;
        er_ptr <= '0;
        er_end <= LAST;
      end else if (er_act) begin
        if (er_ptr == er_end) er_act <= 1'b0;
        else er_ptr <= er_ptr + ADDR_BITS'(1);
      end
    end

  always_ff @(posedge clk)
    if (er_act) mem[er_ptr] <= 8'hFF;
    else if (prog_we) mem[addr] <= mem[addr] & rx_byte;

  a_r7_wel_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |-> wel);
  a_r9_no_prog_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> !wip);
  a_r8_wel_drops_with_wip: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |=> wip);
  a_r5_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> addr[ADDR_BITS-1:8] == $past(addr[ADDR_BITS-1:8]));
  a_r6_erased_ff: assert property (@(posedge clk) disable iff (!rst_n)
    er_act |=> mem[$past(er_ptr)] == 8'hFF);
  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |-> !miso);
endmodule

// File: tb/sim_nor_flash_emu.sv
module sim_nor_flash_emu;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int BUSY = 1000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;

  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];
  event got_ev;

  nor_flash_emu #(.ADDR_BITS(10), .SECTOR_BITS(9), .BUSY_CYCLES(BUSY), .DENSITY_SEL(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  initial forever begin
    @(got_ev);
    while (got_q.size() > 0) check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  task automatic cs_begin();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    spi_byte(tx, d);
  endtask

  task automatic xfer_chk(input logic [7:0] tx, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    spi_byte(tx, r);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    got_q.push_back(r);
    -> got_ev;
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_begin(); send(op); cs_end();
  endtask

  task automatic status_chk(input logic [7:0] exp, input string tag);
    cs_begin(); send(8'h05); xfer_chk(8'h00, exp, tag); cs_end();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    for (int n = 0; n < 300 && s[0]; n++) begin
      cs_begin(); send(8'h05); spi_byte(8'h00, s); cs_end();
    end
    check("R8 busy ends", s & 8'h01, 8'h00);
  endtask

  task automatic op_addr(input logic [7:0] op, input logic [23:0] a);
    send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic prog1(input logic [23:0] a, input logic [7:0] d);
    cmd1(8'h06);
    cs_begin(); op_addr(8'h02, a); send(d); cs_end();
    wait_idle();
  endtask

  task automatic read1(input logic [23:0] a, input logic [7:0] exp, input string tag);
    cs_begin(); op_addr(8'h03, a); xfer_chk(8'h00, exp, tag); cs_end();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s, prev;
    bit bad;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 miso idle", {7'b0, miso}, 8'h00);
    status_chk(8'h01, "R1 wip during init");
    wait_idle();
    status_chk(8'h00, "R1 status after init");
    cs_begin(); op_addr(8'h03, 24'h000000);
    for (int i = 0; i < 4; i++) xfer_chk(8'h00, 8'hFF, "R1 erased after init");
    cs_end();

    cs_begin(); op_addr(8'hAB, 24'h0);
    xfer_chk(8'h00, 8'h15, "R10 signature"); xfer_chk(8'h00, 8'h15, "R10 repeated");
    cs_end();

    cmd1(8'h06); status_chk(8'h02, "R3 wel set");
    cmd1(8'h04); status_chk(8'h00, "R3 wel cleared");

    cs_begin(); op_addr(8'h02, 24'h000010); send(8'h12); cs_end();
    status_chk(8'h00, "R7 program without wel not busy");
    read1(24'h000010, 8'hFF, "R7 program without wel ignored");

    cmd1(8'h06);
    cs_begin(); op_addr(8'h02, 24'h000010); send(8'h12); send(8'h34); cs_end();
    status_chk(8'h03, "R8 wip set after program");
    cmd1(8'h06);
    read1(24'h000010, 8'h00, "R9 read ignored while busy");
    wait_idle();
    status_chk(8'h00, "R9 wren ignored and R8 wel cleared");
    cs_begin(); op_addr(8'h03, 24'hFF0010);
    xfer_chk(8'h00, 8'h12, "R5 program byte0");
    xfer_chk(8'h00, 8'h34, "R5 program byte1");
    xfer_chk(8'h00, 8'hFF, "R4 next untouched");
    cs_end();

    prog1(24'h000010, 8'hF0);
    read1(24'h000010, 8'h10, "R5 AND into cell");

    cmd1(8'h06);
    cs_begin(); op_addr(8'h02, 24'h0001FE);
    send(8'hAA); send(8'hBB); send(8'hCC); send(8'hDD); cs_end();
    wait_idle();
    cs_begin(); op_addr(8'h03, 24'h0001FE);
    xfer_chk(8'h00, 8'hAA, "R5 page end"); xfer_chk(8'h00, 8'hBB, "R5 page end+1");
    xfer_chk(8'h00, 8'hFF, "R5 next page untouched");
    cs_end();
    cs_begin(); op_addr(8'h03, 24'h000100);
    xfer_chk(8'h00, 8'hCC, "R5 wrap offset0"); xfer_chk(8'h00, 8'hDD, "R5 wrap offset1");
    cs_end();

    cmd1(8'h06);
    cs_begin(); op_addr(8'h02, 24'h000050); send(8'h5A); cs_end();
    cs_begin(); send(8'h05);
    prev = 8'h03; bad = 0;
    for (int i = 0; i < 20; i++) begin
      spi_byte(8'h00, s);
      if (i == 0) check("R2 stream first byte", s, 8'h03);
      if (s != 8'h03 && s != 8'h00) bad = 1;
      if (prev == 8'h00 && s == 8'h03) bad = 1;
      prev = s;
    end
    cs_end();
    check("R8 stream last byte", prev, 8'h00);
    check("R8 stream consistent", {7'b0, bad}, 8'h00);

    prog1(24'h000000, 8'h77);
    cs_begin(); op_addr(8'h03, 24'h0003FF);
    xfer_chk(8'h00, 8'hFF, "R4 last address"); xfer_chk(8'h00, 8'h77, "R4 wrap to zero");
    cs_end();

    prog1(24'h0002A0, 8'h11);
    cmd1(8'h06);
    cs_begin(); op_addr(8'hD8, 24'h000123); cs_end();
    wait_idle();
    read1(24'h000010, 8'hFF, "R6 sector erased low");
    read1(24'h000100, 8'hFF, "R6 sector erased mid");
    read1(24'h0002A0, 8'h11, "R6 other sector kept");
    cs_begin(); op_addr(8'hD8, 24'h0002A0); cs_end();
    status_chk(8'h00, "R7 erase without wel");
    read1(24'h0002A0, 8'h11, "R7 erase without wel ignored");
    cmd1(8'h06);
    cs_begin(); send(8'hC7); cs_end();
    wait_idle();
    read1(24'h0002A0, 8'hFF, "R6 bulk erase");
    check("R11 miso idle end", {7'b0, miso}, 8'h00);

    repeat (20) @(negedge clk);
    while (got_q.size() > 0) check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule